// File: doc/BRIEF.md
# Edge-Detect GPIO Interrupt Aggregator

This block sits beside one 32-pin GPIO bank and turns pin transitions into interrupts. Every clock it compares each already-synchronized pin with the value it held one cycle earlier. A pin whose rising-edge enable is set latches a status bit on a 0-to-1 change. A pin whose falling-edge enable is set latches a status bit on a 1-to-0 change.

The latched status bits are OR-reduced in two groups of sixteen. Each group result is gated by that group's bit in a bank-wide enable register. It is then registered and driven out as a clean group interrupt line.

Software programs the block through a plain write port. Separate addresses set and clear the rising enables and the falling enables, and each acts only on the bits written as 1. Writing ones to the status address clears those status bits. The port is a simple strobed write with no back-pressure: a write is accepted in every cycle where `wr_en_i` is high. The status bits come out directly for observation. The pin data registers and the interrupt controller downstream lie outside this block.

Top module: `gpio_edge_irq_agg`

## Requirements
- R1: After reset every rising enable, falling enable, status bit and group enable is 0, and both group interrupts are 0.
- R2: A write to 0x24 sets the rising enable of each pin whose data bit is 1, and a write to 0x28 clears it. Pins written as 0 keep their enable. A pin with only its rising enable set latches status on a 0-to-1 change and not on a 1-to-0 change.
- R3: A write to 0x2C sets the falling enable of each pin whose data bit is 1, and a write to 0x30 clears it. Pins written as 0 keep their enable. A pin with only its falling enable set latches status on a 1-to-0 change and not on a 0-to-1 change.
- R4: A pin with both enables set latches status on either transition. A pin with neither enable set never latches status.
- R5: A write to 0x34 clears each status bit whose data bit is 1 and leaves the other status bits unchanged.
- R6: Group 0 covers status bits 15:0 and drives `grp_irq_o[0]`. Group 1 covers bits 31:16 and drives `grp_irq_o[1]`.
- R7: A write to 0x08 loads the group enables from data bits 1:0, with bit g belonging to group g. A group interrupt is 0 whenever its enable bit is 0, and goes to 1 one cycle after the enable is set if one of its status bits is 1.
- R8: After a status bit has been cleared, a later enabled edge on that pin sets it again, and the group interrupt re-asserts.
- R9: An enabled edge that arrives in the same cycle as a clear of the same status bit wins, and the bit stays 1.
- R10: Each group interrupt is registered: it equals the OR of its group's status bits ANDed with its enable, as they stood one cycle earlier. A new status bit therefore shows on the interrupt one cycle after the status bit itself.
- R11: An edge is detected in the cycle when a pin differs from its value one cycle earlier. Enable changes apply from the cycle after the write. Writes to any address other than 0x08, 0x24, 0x28, 0x2C and 0x30 or 0x34 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | GPIO clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_i | input | 32 | Synchronized pin levels |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 8 | Byte address of the write |
| wr_data_i | input | 32 | Write data, one bit per pin or per group |
| status_o | output | 32 | Latched edge status bits |
| grp_irq_o | output | 2 | Registered, gated group interrupts |

## Verification
Edge detection is tried with single-pin rising steps, falling steps and full pulses on pins that have only the rising enable, only the falling enable, both enables or neither. These patterns tell the two edge types apart and show that the enables are independent. Multi-pin writes with partial masks show that set, clear and status-clear touch only the bits written as 1. Status placed only in the upper half or only in the lower half of the bank shows which group line each pin drives. An edge that coincides with a clear of its own bit exposes the priority between the two. Toggling the group enable while status is pending shows both the gating and the one-cycle registered latency.

// File: rtl/gei_pkg.sv
package gei_pkg;
  localparam int unsigned ADDR_W = 8;

  // register map (byte addresses), ascending order within the bank window
  localparam logic [ADDR_W-1:0] OFS_GRP_EN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_RISE_SET = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_RISE_CLR = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_FALL_SET = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_FALL_CLR = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_STAT_CLR = 8'h34;

  typedef struct packed {
    logic rise_set;
    logic rise_clr;
    logic fall_set;
    logic fall_clr;
    logic stat_clr;
    logic grp_en;
  } wr_strobe_t;
endpackage

// File: rtl/gei_reg_decode.sv
module gei_reg_decode
  import gei_pkg::*;
(
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  output wr_strobe_t        stb_o
);
  always_comb begin
    stb_o = '0;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        OFS_GRP_EN:   stb_o.grp_en   = 1'b1;
        OFS_RISE_SET: stb_o.rise_set = 1'b1;
        OFS_RISE_CLR: stb_o.rise_clr = 1'b1;
        OFS_FALL_SET: stb_o.fall_set = 1'b1;
        OFS_FALL_CLR: stb_o.fall_clr = 1'b1;
        OFS_STAT_CLR: stb_o.stat_clr = 1'b1;
        default:      stb_o = '0; // R11: other addresses ignored
      endcase
    end
  end
endmodule

// File: rtl/gei_edge_cell.sv
module gei_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic rise_set_i,
  input  logic rise_clr_i,
  input  logic fall_set_i,
  input  logic fall_clr_i,
  input  logic stat_clr_i,
  output logic stat_o
);
  logic prev_q, rise_en_q, fall_en_q, stat_q;
  logic hit;

  // R11: edge = current level differs from the level one clock earlier
  assign hit = (rise_en_q &  pin_i & ~prev_q) |
               (fall_en_q & ~pin_i &  prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      rise_en_q <= 1'b0;
      fall_en_q <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      prev_q <= pin_i;
      if (rise_set_i)      rise_en_q <= 1'b1;
      else if (rise_clr_i) rise_en_q <= 1'b0;
      if (fall_set_i)      fall_en_q <= 1'b1;
      else if (fall_clr_i) fall_en_q <= 1'b0;
      // R9: a fresh edge overrides a clear in the same cycle
      stat_q <= hit | (stat_q & ~stat_clr_i);
    end
  end

  assign stat_o = stat_q;

  // R9
  r9_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> stat_q);
  // R5
  r5_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !hit) |=> !stat_q);
  // R4
  r4_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise_en_q && !fall_en_q && !stat_q) |=> !stat_q);
endmodule

// File: rtl/gei_group_irq.sv
module gei_group_irq #(
  parameter int unsigned GROUP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] stat_i,
  input  logic               en_i,
  output logic               irq_o
);
  logic irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= en_i & (|stat_i);
  end

  assign irq_o = irq_q;

  // R10
  r10_registered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(en_i && (|stat_i))));
  // R7
  r7_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !irq_o);
endmodule

// File: rtl/gpio_edge_irq_agg.sv
module gpio_edge_irq_agg
  import gei_pkg::*;
#(
  parameter int unsigned PINS    = 32,
  parameter int unsigned GROUP_W = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [PINS-1:0]                 pin_i,
  input  logic                            wr_en_i,
  input  logic [ADDR_W-1:0]               wr_addr_i,
  input  logic [PINS-1:0]                 wr_data_i,
  output logic [PINS-1:0]                 status_o,
  output logic [(PINS/GROUP_W)-1:0]       grp_irq_o
);
  localparam int unsigned NGROUPS = PINS / GROUP_W;

  wr_strobe_t          stb;
  logic [PINS-1:0]     stat;
  logic [NGROUPS-1:0]  grp_en_q;

  gei_reg_decode u_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .stb_o     (stb)
  );

  // R7: bank-wide group enable register
  always_ff @(posedge clk) begin
    if (!rst_n)          grp_en_q <= '0;
    else if (stb.grp_en) grp_en_q <= wr_data_i[NGROUPS-1:0];
  end

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    gei_edge_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .pin_i      (pin_i[p]),
      .rise_set_i (stb.rise_set & wr_data_i[p]),
      .rise_clr_i (stb.rise_clr & wr_data_i[p]),
      .fall_set_i (stb.fall_set & wr_data_i[p]),
      .fall_clr_i (stb.fall_clr & wr_data_i[p]),
      .stat_clr_i (stb.stat_clr & wr_data_i[p]),
      .stat_o     (stat[p])
    );
  end

  // R6: group g covers bits g*GROUP_W +: GROUP_W
  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    gei_group_irq #(.GROUP_W(GROUP_W)) u_grp (
      .clk    (clk),
      .rst_n  (rst_n),
      .stat_i (stat[g*GROUP_W +: GROUP_W]),
      .en_i   (grp_en_q[g]),
      .irq_o  (grp_irq_o[g])
    );
  end

  assign status_o = stat;

  // R6
  r6_group_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[GROUP_W-1:0] == '0) |=> !grp_irq_o[0]);
  // R1
  r1_reset_chk: assert property (@(posedge clk)
    !rst_n |=> (status_o == '0 && grp_irq_o == '0));
endmodule

// File: tb/gpio_edge_irq_agg_tb.sv
module gpio_edge_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pins = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic [1:0]  irq;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk; // 200 MHz

  gpio_edge_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .status_o(status), .grp_irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); pins = v;
    @(negedge clk);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr(8'h24, '0); wr(8'h28, '1); wr(8'h30, '1); wr(8'h34, '1); step(); step();
  endtask

  task automatic t_reset();
    chk("R1 status after reset", status, 32'h0);
    chk("R1 irq after reset", {30'h0, irq}, 32'h0);
    drive(32'hFFFF_FFFF); drive(32'h0);
    chk("R4/R1 no enable no status", status, 32'h0);
  endtask

  task automatic t_rise();
    wr(8'h08, 32'h3);
    wr(8'h24, 32'h4);
    drive(32'h4);
    chk("R2 rise latched", status, 32'h4);
    chk("R10 irq lags status", {30'h0, irq}, 32'h0);
    step();
    chk("R10 irq one cycle later", {30'h0, irq}, 32'h1);
    wr(8'h34, 32'h4);
    chk("R5 cleared", status, 32'h0);
    drive(32'h0);
    chk("R2 fall ignored on rise-only pin", status, 32'h0);
    wr(8'h24, 32'h28); wr(8'h28, 32'h08);
    drive(32'h28);
    chk("R2 only written bits cleared", status, 32'h20);
    clear_all(); drive(32'h0);
  endtask

  task automatic t_fall();
    wr(8'h2C, 32'h0010_0000);
    drive(32'h0010_0000);
    chk("R3 rise ignored on fall-only pin", status, 32'h0);
    drive(32'h0);
    chk("R3 fall latched", status, 32'h0010_0000);
    step();
    chk("R6 upper group drives irq1", {30'h0, irq}, 32'h2);
    wr(8'h30, 32'h0010_0000); wr(8'h34, '1);
    drive(32'h0010_0000); drive(32'h0);
    chk("R3 fall enable cleared", status, 32'h0);
    clear_all();
  endtask

  task automatic t_both();
    wr(8'h24, 32'h80); wr(8'h2C, 32'h80);
    drive(32'h80);
    chk("R4 both: rise", status, 32'h80);
    wr(8'h34, 32'h80);
    drive(32'h0);
    chk("R4 both: fall", status, 32'h80);
    wr(8'h34, 32'h80);
    drive(32'h100); drive(32'h0);
    chk("R4 neither enabled pin quiet", status, 32'h0);
    clear_all();
  endtask

  task automatic t_partial_w1c();
    wr(8'h24, 32'hA0);
    drive(32'hA0);
    wr(8'h34, 32'h80);
    chk("R5 only written status bit cleared", status, 32'h20);
    step(); step();
    chk("R6 lower group drives irq0", {30'h0, irq}, 32'h1);
    clear_all(); drive(32'h0);
  endtask

  task automatic t_gate_rearm();
    wr(8'h08, 32'h0);
    wr(8'h24, 32'h4);
    drive(32'h4); step(); step();
    chk("R7 gated irq stays low", {30'h0, irq}, 32'h0);
    wr(8'h08, 32'h1);
    chk("R7 enable reaches irq next cycle", {30'h0, irq}, 32'h0);
    step();
    chk("R7 irq asserted after enable", {30'h0, irq}, 32'h1);
    wr(8'h34, 32'h4); step();
    chk("R8 irq drops after clear", {30'h0, irq}, 32'h0);
    drive(32'h0); drive(32'h4); step();
    chk("R8 status re-latched", status, 32'h4);
    chk("R8 irq re-asserts", {30'h0, irq}, 32'h1);
    wr(8'h08, 32'h3);
    clear_all(); drive(32'h0);
  endtask

  task automatic t_collision();
    wr(8'h24, 32'h1);
    drive(32'h1); drive(32'h0);
    chk("R9 setup status set", status, 32'h1);
    @(negedge clk); pins = 32'h1; wr_en = 1'b1; wr_addr = 8'h34; wr_data = 32'h1;
    @(negedge clk); wr_en = 1'b0;
    chk("R9 edge beats clear", status, 32'h1);
    clear_all(); drive(32'h0);
  endtask

  task automatic t_map();
    wr(8'h20, '1); wr(8'h2D, '1);
    drive(32'hFFFF); drive(32'h0);
    chk("R11 unmapped writes ignored", status, 32'h0);
    @(negedge clk); pins = 32'h2; wr_en = 1'b1; wr_addr = 8'h24; wr_data = 32'h2;
    @(negedge clk); wr_en = 1'b0;
    chk("R11 enable applies next cycle", status, 32'h0);
    drive(32'h0);
    chk("R11 fall not enabled", status, 32'h0);
    drive(32'h2);
    chk("R11 edge after enable", status, 32'h2);
    clear_all(); drive(32'h0);
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_partial_w1c();
    t_gate_rearm();
    t_collision();
    t_map();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule